// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two IEEE-754 single-precision numbers. It works through five steps in order. It adds the biased exponents and takes one bias away. It multiplies the two 24-bit significands with their hidden ones restored. It normalizes the 48-bit product and rounds it to 23 fraction bits with round-to-nearest-even, normalizing a second time if the rounding carries out. It then checks the final exponent for overflow and underflow. The result sign is the XOR of the operand signs.

The block is a two-stage pipeline with a valid qualifier on each side. It accepts one operation per clock and has no stall path. Subnormal inputs count as zero. Results too small to represent become signed zero. Zero, infinity and NaN operands take fixed paths that bypass the arithmetic.

Top module: `fpm_mul`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly two clock cycles. A new operation can be accepted on every cycle. After reset, `out_valid` and all three flags read 0.
- R2: For every result that is not NaN, the sign bit [31] equals the XOR of the operand sign bits.
- R3: For normal operands, the result's biased exponent is the sum of the operand exponents (bits [30:23]) minus 127, plus any normalization step. For example, 0x3F000000 × 0xBEE00000 (0.5 × -0.4375) gives exponent 124 and result 0xBE600000 (-0.21875).
- R4: If the significand product is 2 or more, it is shifted right by one place and the exponent goes up by one. For example, 0x3FC00000 × 0x3FC00000 gives 0x40100000.
- R5: Rounding is to nearest, with ties going to the even value. The guard bit and sticky bits come from the discarded low part of the product. For example, 0x3F800001 × 0x3FC00000 gives 0x3FC00002, and 0x3F800003 × 0x3FC00000 gives 0x3FC00004.
- R6: If rounding carries out of the significand, the result is normalized again and the exponent goes up by one. For example, 0x3FFFFFFE × 0x3F800001 gives 0x40000000.
- R7: If the final biased exponent is 255 or more, the result is a signed infinity (exponent all ones, fraction 0) and `out_ovf` = 1.
- R8: If the final biased exponent is 0 or less, the result is a signed zero and `out_unf` = 1.
- R9: An operand whose exponent field is 0 counts as zero, whatever its fraction. Multiplying it by a finite value gives a signed zero with no flag raised.
- R10: Zero × infinity gives the canonical NaN 0x7FC00000 with `out_inv` = 1. Any NaN operand gives 0x7FC00000 with no flag raised.
- R11: Infinity × a finite nonzero value, or infinity × infinity, gives a signed infinity with no flag raised. At most one of the three flags is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result is valid |
| out_result | output | 32 | Product |
| out_ovf | output | 1 | Exponent overflow; the result is infinity |
| out_unf | output | 1 | Exponent underflow; the result is zero |
| out_inv | output | 1 | Invalid zero × infinity; the result is NaN |

## Verification
Directed pairs target specific parts of the datapath:
- The worked example and the 1.5 × 1.5 case separate a product below 2 from a product of 2 or more.
- Two exact ties, one with an odd kept bit and one with an even kept bit, show whether ties go to even or simply round up.
- A product just under 2 that rounds up shows whether the block renormalizes after rounding.
- Operands at the top and bottom of the exponent range separate overflow from underflow, each with both signs.
- Zero, subnormal, infinity and NaN operands check the priority order of the special-value paths.

Random operands with mid-range exponents, mixed with fully random words and with gaps in `in_valid`, check rounding in general and the two-cycle valid alignment under back-to-back traffic.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = 2 * MANT_W;
  localparam int ESUM_W  = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {CLS_ZERO, CLS_NORM, CLS_INF, CLS_NAN} opcls_t;
  typedef enum logic [2:0] {K_NUM, K_ZERO, K_INF, K_NAN, K_INV} kind_t;

  typedef struct packed {
    logic              sign;
    opcls_t            cls;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;
  } operand_t;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output operand_t          op
);
  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] f_fld;

  always_comb begin
    e_fld   = word[WORD_W-2 -: EXP_W];
    f_fld   = word[FRAC_W-1:0];
    op.sign = word[WORD_W-1];
    op.exp  = e_fld;
    op.mant = {1'b1, f_fld};
    if (e_fld == '0)                op.cls = CLS_ZERO;
    else if (e_fld != {EXP_W{1'b1}}) op.cls = CLS_NORM;
    else if (f_fld == '0)           op.cls = CLS_INF;
    else                            op.cls = CLS_NAN;
  end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
  import fpm_pkg::*;
(
  input  logic [MANT_W-1:0] mant_a,
  input  logic [MANT_W-1:0] mant_b,
  output logic [PROD_W-1:0] prod
);
  always_comb prod = PROD_W'(mant_a) * PROD_W'(mant_b);
endmodule

// File: rtl/fpm_normround.sv
module fpm_normround
  import fpm_pkg::*;
(
  input  logic                     sign,
  input  logic signed [ESUM_W-1:0] esum,
  input  logic [PROD_W-1:0]        prod,
  output logic [WORD_W-1:0]        word,
  output logic                     ovf,
  output logic                     unf
);
  logic                     hi;
  logic [PROD_W-1:0]        aligned;
  logic [MANT_W-1:0]        kept;
  logic                     guard, sticky, bump;
  logic [MANT_W:0]          rsum;
  logic [FRAC_W-1:0]        frac;
  logic signed [ESUM_W-1:0] e_norm, e_fin;

  always_comb begin
    // step 3: normalize, product in [1,4)
    hi      = prod[PROD_W-1];
    aligned = hi ? prod : (prod << 1);
    e_norm  = hi ? (esum + ESUM_W'(1)) : esum;
    // step 4: nearest-even rounding
    kept    = aligned[PROD_W-1 -: MANT_W];
    guard   = aligned[PROD_W-1-MANT_W];
    sticky  = |aligned[PROD_W-2-MANT_W:0];
    bump    = guard & (sticky | kept[0]);
    rsum    = {1'b0, kept} + (MANT_W+1)'(bump);
    // renormalize when the round carried out
    if (rsum[MANT_W]) begin
      frac  = rsum[FRAC_W:1];
      e_fin = e_norm + ESUM_W'(1);
    end else begin
      frac  = rsum[FRAC_W-1:0];
      e_fin = e_norm;
    end
    ovf = (e_fin >= ESUM_W'(EXP_MAX));
    unf = (e_fin <= ESUM_W'(0));
    if (ovf)      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (unf) word = {sign, {(WORD_W-1){1'b0}}};
    else          word = {sign, e_fin[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_inv
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // stage 1: classify, exponent sum, significand product
  operand_t                 op_a, op_b;
  logic [PROD_W-1:0]        prod_d;
  kind_t                    kind_d;
  logic                     sign_d;
  logic signed [ESUM_W-1:0] esum_d;

  fpm_unpack u_unpack_a (.word(in_a), .op(op_a));
  fpm_unpack u_unpack_b (.word(in_b), .op(op_b));
  fpm_sigmul u_sigmul (.mant_a(op_a.mant), .mant_b(op_b.mant), .prod(prod_d));

  always_comb begin
    sign_d = op_a.sign ^ op_b.sign;
    esum_d = $signed({2'b00, op_a.exp}) + $signed({2'b00, op_b.exp})
             - ESUM_W'(BIAS);
    if (op_a.cls == CLS_NAN || op_b.cls == CLS_NAN)
      kind_d = K_NAN;
    else if ((op_a.cls == CLS_INF && op_b.cls == CLS_ZERO) ||
             (op_a.cls == CLS_ZERO && op_b.cls == CLS_INF))
      kind_d = K_INV;
    else if (op_a.cls == CLS_INF || op_b.cls == CLS_INF)
      kind_d = K_INF;
    else if (op_a.cls == CLS_ZERO || op_b.cls == CLS_ZERO)
      kind_d = K_ZERO;
    else
      kind_d = K_NUM;
  end

  logic                     s1_valid;
  kind_t                    s1_kind;
  logic                     s1_sign;
  logic signed [ESUM_W-1:0] s1_esum;
  logic [PROD_W-1:0]        s1_prod;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid <= 1'b0;
      s1_kind  <= K_ZERO;
      s1_sign  <= 1'b0;
      s1_esum  <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_kind <= kind_d;
        s1_sign <= sign_d;
        s1_esum <= esum_d;
        s1_prod <= prod_d;
      end
    end
  end

  // stage 2: normalize, round, exceptions
  logic [WORD_W-1:0] num_word;
  logic              num_ovf, num_unf;
  logic [WORD_W-1:0] res_d;
  logic              ovf_d, unf_d, inv_d;

  fpm_normround u_normround (
    .sign(s1_sign), .esum(s1_esum), .prod(s1_prod),
    .word(num_word), .ovf(num_ovf), .unf(num_unf)
  );

  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    inv_d = 1'b0;
    case (s1_kind)
      K_NUM: begin
        res_d = num_word;
        ovf_d = num_ovf;
        unf_d = num_unf;
      end
      K_INF:   res_d = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_NAN:   res_d = QNAN_WORD;
      K_INV: begin
        res_d = QNAN_WORD;
        inv_d = 1'b1;
      end
      default: res_d = {s1_sign, {(WORD_W-1){1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_unf    <= 1'b0;
      out_inv    <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_result <= res_d;
        out_ovf    <= ovf_d;
        out_unf    <= unf_d;
        out_inv    <= inv_d;
      end
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
  import fpm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_result,
  input logic              out_ovf,
  input logic              out_unf,
  input logic              out_inv
);
  logic res_is_nan, res_is_inf, res_is_zero, a_is_inf, b_is_norm;
  assign res_is_nan  = (out_result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) &&
                       (out_result[FRAC_W-1:0] != '0);
  assign res_is_inf  = (out_result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
  assign res_is_zero = (out_result[WORD_W-2:0] == '0);
  assign a_is_inf    = (in_a[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
  assign b_is_norm   = (in_b[WORD_W-2 -: EXP_W] != '0) &&
                       (in_b[WORD_W-2 -: EXP_W] != {EXP_W{1'b1}});

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !res_is_nan) |->
      (out_result[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1], 2)));

  a_r7_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> res_is_inf);

  a_r8_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> res_is_zero);

  a_r10_inv_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv) |-> (out_result == QNAN_WORD));

  a_r11_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_ovf, out_unf, out_inv}));

  a_r11_inf_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && a_is_inf && b_is_norm, 2)) |-> res_is_inf);
endmodule

bind fpm_mul fpm_mul_chk u_chk (.*);

// File: tb/fpm_mul_bench.sv
`timescale 1ns/1ps
module fpm_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ovf, out_unf, out_inv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpm_mul u_fpm_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result),
    .out_ovf(out_ovf), .out_unf(out_unf), .out_inv(out_inv)
  );

  // expected word: {inv, unf, ovf, result}
  function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    int ea, eb, e, drop;
    bit az, bz, ai, bi, an, bn, sg;
    longint p, q, rem, half;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    az = (ea == 0);
    bz = (eb == 0);
    ai = (ea == 255) && (a[22:0] == 0);
    bi = (eb == 255) && (b[22:0] == 0);
    an = (ea == 255) && (a[22:0] != 0);
    bn = (eb == 255) && (b[22:0] != 0);
    sg = a[31] ^ b[31];
    if (an || bn) return {3'b000, 32'h7FC00000};
    if ((ai && bz) || (az && bi)) return {3'b100, 32'h7FC00000};
    if (ai || bi) return {3'b000, sg, 8'hFF, 23'h0};
    if (az || bz) return {3'b000, sg, 31'h0};
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = ea + eb - 127;
    drop = (p >= (longint'(1) << 47)) ? 24 : 23;
    e = e + drop - 23;
    q = p >> drop;
    rem = p - (q << drop);
    half = longint'(1) << (drop - 1);
    if (rem > half || (rem == half && q[0])) q = q + 1;
    if (q == (longint'(1) << 24)) begin
      q = q >> 1;
      e = e + 1;
    end
    if (e >= 255) return {3'b001, sg, 8'hFF, 23'h0};
    if (e <= 0) return {3'b010, sg, 31'h0};
    return {3'b000, sg, e[7:0], q[22:0]};
  endfunction

  // in-flight expectations, two stages deep
  logic        p1_v = 1'b0, p2_v = 1'b0;
  logic [34:0] p1_e = '0, p2_e = '0;
  string       p1_t = "", p2_t = "";

  task automatic check_val(input logic [34:0] got, input logic [34:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    check_val({34'h0, out_valid}, {34'h0, p2_v}, "R1 out_valid alignment");
    if (p2_v) check_val({out_inv, out_unf, out_ovf, out_result}, p2_e, p2_t);
    p2_v = p1_v; p2_e = p1_e; p2_t = p1_t;
    p1_v = v;
    p1_e = v ? ref_mul(a, b) : '0;
    p1_t = tag;
    in_valid = v;
    in_a = a;
    in_b = b;
  endtask

  function automatic logic [31:0] rnd_operand();
    logic [31:0] w;
    w = $urandom;
    if (($urandom % 8) != 0) w[30:23] = 8'(100 + ($urandom % 55));
    return w;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val({31'h0, out_valid, out_ovf, out_unf, out_inv}, '0, "R1 reset state");

    step(1, 32'h3F000000, 32'hBEE00000, "R3 worked example 0.5*-0.4375");
    step(1, 32'h3FC00000, 32'h3FC00000, "R4 product>=2 shift right");
    step(1, 32'h3F800001, 32'h3FC00000, "R5 tie odd rounds up");
    step(1, 32'h3F800003, 32'h3FC00000, "R5 tie even stays");
    step(1, 32'h3FFFFFFE, 32'h3F800001, "R6 round carry renormalize");
    step(0, 32'h0, 32'h0, "idle");
    step(1, 32'h7F000000, 32'h40000000, "R7 overflow positive");
    step(1, 32'hFF000000, 32'h40000000, "R7 overflow negative");
    step(1, 32'h00800000, 32'h00800000, "R8 underflow positive");
    step(1, 32'h80800000, 32'h00800000, "R8 underflow negative");
    step(1, 32'h80000000, 32'h40A00000, "R9 negative zero times five");
    step(1, 32'h00000001, 32'hC0000000, "R9 subnormal flushes");
    step(1, 32'h00000000, 32'h7F800000, "R10 zero times inf");
    step(1, 32'h7FC12345, 32'h3F800000, "R10 nan operand");
    step(1, 32'h7F800000, 32'hC0000000, "R11 inf times negative");
    step(1, 32'hFF800000, 32'hFF800000, "R11 inf times inf");
    step(1, 32'hBF800000, 32'h3F800000, "R2 sign xor -1*1");
    step(1, 32'hC0400000, 32'hC0800000, "R2 sign xor -3*-4");

    for (int i = 0; i < 400; i++) begin
      if (($urandom % 5) == 0) step(0, 32'h0, 32'h0, "idle");
      else step(1, rnd_operand(), rnd_operand(), "R5 random operands");
    end
    step(0, 32'h0, 32'h0, "flush");
    step(0, 32'h0, 32'h0, "flush");
    step(0, 32'h0, 32'h0, "flush");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule